// File: doc/BRIEF.md
# Flash Program/Erase Protection Checker

This block stores an 8-bit protection setting for the on-chip program flash and decides, for each program or erase command, whether the target global address may be changed. The setting defines two windows. The upper window always ends at the highest global address and grows downward in one of four sizes. The lower window always starts at the base of the modelled flash array and grows upward in one of four sizes. A mode bit chooses how these windows are used. In one setting they are the protected areas. In the other setting they are the only writable areas.

The command sequencer presents a 23-bit global address together with a valid strobe. One clock later the block returns a registered deny flag. The flag holds its value until the next strobe. The size field of each window can only be changed while that window is switched off. Software must therefore disable a window, resize it, and then enable it again.

Top module: `flash_guard`

## Requirements
- R1: After reset the setting reads 0xFF and the deny flag is 0.
- R2: Setting layout: bit 7 is the mode bit, bit 6 is spare, bit 5 switches the upper window off, bits 4:3 are the upper size code, bit 2 switches the lower window off, and bits 1:0 are the lower size code. Any write loads bits 7, 5 and 2 directly. Bit 6 always reads 1 and has no effect on the decode.
- R3: A write changes bits 4:3 only if the stored bit 5 was 1 before the write. Otherwise the old code is kept.
- R4: A write changes bits 1:0 only if the stored bit 2 was 1 before the write. Otherwise the old code is kept.
- R5: The upper window ends at 0x7F_FFFF. Its start address is 0x7F_F800, 0x7F_F000, 0x7F_E000 or 0x7F_C000 for size codes 0, 1, 2 and 3.
- R6: The lower window starts at 0x7F_8000. Its length is 1, 2, 4 or 8 KB for size codes 0, 1, 2 and 3.
- R7: With the mode bit at 1, a command is denied exactly when its address lies in an enabled window. With both windows off, nothing is denied.
- R8: With the mode bit at 0, a command is denied exactly when its address lies in no enabled window. This includes every address below 0x7F_8000. With both windows off, everything is denied.
- R9: The deny flag is updated on the clock edge that samples the command strobe. The decision uses the setting as it was before any write in that same cycle. Without a strobe the flag holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Setting write enable |
| cfg_wdata | input | 8 | Setting write data |
| cfg_rdata | output | 8 | Current setting |
| cmd_valid | input | 1 | Program/erase command strobe |
| cmd_addr | input | 23 | Global target address of the command |
| deny | output | 1 | Registered protection-violation flag |

## Verification
The bench builds the block with its default parameters: a 23-bit address, a 32 KB array, a 2 KB minimum upper window and a 1 KB minimum lower window. At this size the bench can reach every one of the 256 setting values and test each one. For each value it probes the first and last address of every possible window, the addresses just outside those windows, and addresses below the array. After each value it flips both size codes to check the locks. A separate sequence issues a write and a command in the same cycle to confirm that the decision uses the old setting.

// File: rtl/guard_pkg.sv
package guard_pkg;

   localparam int SZ_W = 2;

   // Bit order matches the software-visible setting byte.
   typedef struct packed {
      logic            open_mode;
      logic            spare;
      logic            hi_off;
      logic [SZ_W-1:0] hi_sz;
      logic            lo_off;
      logic [SZ_W-1:0] lo_sz;
   } guard_cfg_t;

endpackage

// File: rtl/guard_cfg_reg.sv
module guard_cfg_reg
   import guard_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [7:0] wdata,
   output guard_cfg_t cfg
);

   guard_cfg_t wr;
   guard_cfg_t q;
   logic       unused_spare;

   assign wr           = guard_cfg_t'(wdata);
   assign unused_spare = wr.spare;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q.open_mode <= 1'b1;
         q.hi_off    <= 1'b1;
         q.hi_sz     <= '1;
         q.lo_off    <= 1'b1;
         q.lo_sz     <= '1;
      end else if (we) begin
         q.open_mode <= wr.open_mode;
         q.hi_off    <= wr.hi_off;
         q.lo_off    <= wr.lo_off;
         // size codes move only while their window is switched off
         if (q.hi_off) q.hi_sz <= wr.hi_sz;
         if (q.lo_off) q.lo_sz <= wr.lo_sz;
      end
   end

   // spare bit is not stored; it always presents its erased value
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q.spare <= 1'b1;
      else        q.spare <= 1'b1;
   end

   assign cfg = q;

endmodule

// File: rtl/guard_window.sv
module guard_window #(
   parameter int                  ADDR_W     = 23,
   parameter int                  SZ_W       = 2,
   parameter int                  MIN_LOG2   = 10,
   parameter bit                  ANCHOR_TOP = 1'b0,
   parameter logic [ADDR_W-1:0]   EDGE       = '1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SZ_W-1:0]   size,
   input  logic              en,
   output logic              hit
);

   localparam int SPAN_W = ADDR_W + 1;
   localparam logic [SPAN_W-1:0] EDGE_X = {1'b0, EDGE};

   logic [SPAN_W-1:0] span;
   logic [SPAN_W-1:0] a_x;

   assign a_x  = {1'b0, addr};
   assign span = SPAN_W'(1) << (MIN_LOG2 + int'(size));

   generate
      if (ANCHOR_TOP) begin : g_top
         // window [EDGE-span+1, EDGE]
         assign hit = en && (a_x <= EDGE_X) && ((a_x + span) > EDGE_X);
      end else begin : g_base
         // window [EDGE, EDGE+span-1]
         assign hit = en && (a_x >= EDGE_X) && (a_x < (EDGE_X + span));
      end
   endgenerate

endmodule

// File: rtl/guard_policy.sv
module guard_policy (
   input  logic open_mode,
   input  logic hi_hit,
   input  logic lo_hit,
   output logic prot
);

   logic any_hit;

   assign any_hit = hi_hit | lo_hit;
   // open mode: windows are guarded; closed mode: windows are the only free area
   assign prot    = open_mode ? any_hit : ~any_hit;

endmodule

// File: rtl/flash_guard.sv
module flash_guard
   import guard_pkg::*;
#(
   parameter int ADDR_W      = 23,
   parameter int ARRAY_LOG2  = 15,
   parameter int HI_MIN_LOG2 = 11,
   parameter int LO_MIN_LOG2 = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   input  logic              cmd_valid,
   input  logic [ADDR_W-1:0] cmd_addr,
   output logic              deny
);

   localparam int                SZ_MAX     = (1 << SZ_W) - 1;
   localparam logic [ADDR_W-1:0] TOP_ADDR   = '1;
   localparam logic [ADDR_W-1:0] ARRAY_SPAN = ADDR_W'((64'd1 << ARRAY_LOG2) - 64'd1);
   localparam logic [ADDR_W-1:0] ARRAY_BASE = TOP_ADDR - ARRAY_SPAN;

   generate
      if (ARRAY_LOG2 >= ADDR_W) begin : g_bad_array
         $error("flash_guard: array must be smaller than the address space");
      end
      if (HI_MIN_LOG2 + SZ_MAX > ARRAY_LOG2) begin : g_bad_hi
         $error("flash_guard: largest upper window exceeds the array");
      end
      if (LO_MIN_LOG2 + SZ_MAX > ARRAY_LOG2) begin : g_bad_lo
         $error("flash_guard: largest lower window exceeds the array");
      end
   endgenerate

   guard_cfg_t cfg;
   logic       hi_hit;
   logic       lo_hit;
   logic       prot;

   guard_cfg_reg u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .cfg   (cfg)
   );

   guard_window #(
      .ADDR_W     (ADDR_W),
      .SZ_W       (SZ_W),
      .MIN_LOG2   (HI_MIN_LOG2),
      .ANCHOR_TOP (1'b1),
      .EDGE       (TOP_ADDR)
   ) u_hi (
      .addr (cmd_addr),
      .size (cfg.hi_sz),
      .en   (~cfg.hi_off),
      .hit  (hi_hit)
   );

   guard_window #(
      .ADDR_W     (ADDR_W),
      .SZ_W       (SZ_W),
      .MIN_LOG2   (LO_MIN_LOG2),
      .ANCHOR_TOP (1'b0),
      .EDGE       (ARRAY_BASE)
   ) u_lo (
      .addr (cmd_addr),
      .size (cfg.lo_sz),
      .en   (~cfg.lo_off),
      .hit  (lo_hit)
   );

   guard_policy u_pol (
      .open_mode (cfg.open_mode),
      .hi_hit    (hi_hit),
      .lo_hit    (lo_hit),
      .prot      (prot)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         deny <= 1'b0;
      else if (cmd_valid) deny <= prot;
   end

   assign cfg_rdata = 8'(cfg);

endmodule

// File: rtl/guard_chk.sv
module guard_chk #(
   parameter int ADDR_W     = 23,
   parameter int ARRAY_LOG2 = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [7:0]        cfg_wdata,
   input logic [7:0]        cfg_rdata,
   input logic              cmd_valid,
   input logic [ADDR_W-1:0] cmd_addr,
   input logic              deny
);

   localparam logic [ADDR_W-1:0] BASE =
      ADDR_W'({ADDR_W{1'b1}}) - ADDR_W'((64'd1 << ARRAY_LOG2) - 64'd1);

   logic unused_bits;
   assign unused_bits = cfg_wdata[6];

   // R2
   direct_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (cfg_rdata[7] == $past(cfg_wdata[7])) &&
                 (cfg_rdata[5] == $past(cfg_wdata[5])) &&
                 (cfg_rdata[2] == $past(cfg_wdata[2])) && cfg_rdata[6]);

   // R3
   hi_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rdata[5] |=> cfg_rdata[4:3] == $past(cfg_rdata[4:3]));

   // R3
   hi_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && cfg_rdata[5] |=> cfg_rdata[4:3] == $past(cfg_wdata[4:3]));

   // R4
   lo_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rdata[2] |=> cfg_rdata[1:0] == $past(cfg_rdata[1:0]));

   // R4
   lo_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && cfg_rdata[2] |=> cfg_rdata[1:0] == $past(cfg_wdata[1:0]));

   // R7
   open_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cfg_rdata[7] && cfg_rdata[5] && cfg_rdata[2] |=> !deny);

   // R8
   closed_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cfg_rdata[7] && cfg_rdata[5] && cfg_rdata[2] |=> deny);

   // R8
   closed_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cfg_rdata[7] && (cmd_addr < BASE) |=> deny);

   // R9
   deny_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> $stable(deny));

endmodule

bind flash_guard guard_chk #(.ADDR_W(ADDR_W), .ARRAY_LOG2(ARRAY_LOG2)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_wdata (cfg_wdata),
   .cfg_rdata (cfg_rdata),
   .cmd_valid (cmd_valid),
   .cmd_addr  (cmd_addr),
   .deny      (deny)
);

// File: tb/sim_flash_guard.sv
module sim_flash_guard;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 23;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [7:0]        cfg_wdata = 8'h00;
   logic [7:0]        cfg_rdata;
   logic              cmd_valid = 1'b0;
   logic [ADDR_W-1:0] cmd_addr = '0;
   logic              deny;

   int  n_run  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_guard u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .cmd_valid (cmd_valid),
      .cmd_addr  (cmd_addr),
      .deny      (deny)
   );

   function automatic bit ref_deny(logic [7:0] r, int a);
      int  hs = 'h80_0000 - (2048 << r[4:3]);
      int  le = 'h7F_8000 + (1024 << r[1:0]);
      bit  hh = !r[5] && (a >= hs) && (a <= 'h7F_FFFF);
      bit  lh = !r[2] && (a >= 'h7F_8000) && (a < le);
      return r[7] ? (hh | lh) : !(hh | lh);
   endfunction

   task automatic check(string req, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cmd(int a, logic [7:0] r, string req);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_addr = ADDR_W'(a);
      @(negedge clk);
      cmd_valid = 1'b0;
      check(req, int'(deny), int'(ref_deny(r, a)));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] exp;
      int addrs[$];
      addrs.push_back(0);
      addrs.push_back('h40_0000);
      addrs.push_back('h7F_7FFF);
      addrs.push_back('h7F_8000);
      addrs.push_back('h7F_FFFF);
      for (int k = 0; k < 4; k++) begin
         addrs.push_back('h80_0000 - (2048 << k) - 1);
         addrs.push_back('h80_0000 - (2048 << k));
         addrs.push_back('h7F_8000 + (1024 << k) - 1);
         addrs.push_back('h7F_8000 + (1024 << k));
      end

      repeat (3) @(negedge clk);
      // R1
      check("R1 reset setting", int'(cfg_rdata), 'hFF);
      check("R1 reset deny", int'(deny), 0);
      rst_n = 1'b1;

      for (int v = 0; v < 256; v++) begin
         logic [7:0] w;
         wr(8'hFF);
         wr({v[7], 2'b11, v[4:3], 1'b1, v[1:0]});
         wr(8'(v));
         exp = {v[7], 1'b1, v[5:0]};
         // R2: direct bits, spare reads 1
         check("R2 setting readback", int'(cfg_rdata), int'(exp));
         foreach (addrs[i]) begin
            string req = exp[7] ? "R7 open decode R5 R6" : "R8 closed decode R5 R6";
            cmd(addrs[i], exp, req);
         end
         // R3 R4: flip both size codes
         w = 8'(v) ^ 8'h1B;
         wr(w);
         exp[4:3] = exp[5] ? w[4:3] : exp[4:3];
         exp[1:0] = exp[2] ? w[1:0] : exp[1:0];
         check(exp[5] ? "R3 size write" : "R3 size lock", int'(cfg_rdata[4:3]), int'(exp[4:3]));
         check(exp[2] ? "R4 size write" : "R4 size lock", int'(cfg_rdata[1:0]), int'(exp[1:0]));
      end

      // R9: write and command in one cycle use the old setting
      wr(8'hFF);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = 8'h7F;
      cmd_valid = 1'b1; cmd_addr = ADDR_W'('h7F_FFFF);
      @(negedge clk);
      cfg_we = 1'b0; cmd_valid = 1'b0;
      check("R9 old setting used", int'(deny), 0);
      cmd('h7F_FFFF, 8'h7F, "R8 all denied after write");
      // R9: hold without strobe while address moves
      cmd_addr = '0;
      wr(8'hFF);
      repeat (3) @(negedge clk);
      check("R9 hold", int'(deny), 1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule